// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame should be kept, based only on its 48-bit destination MAC address. The six address bytes arrive one per accepted transfer on a valid/ready byte stream, first byte first. While they stream in, a 32-bit CRC is updated serially over all 48 address bits. After the last byte, a 6-bit bin index is derived from the CRC remainder and used to look up one bit of a 64-bit hash table. Software loads the table as two 32-bit words through a simple write port.

One cycle after the final byte is taken, the block raises a one-cycle done pulse. With it come an accept flag, a decision code saying why the frame was kept or dropped, and the computed bin index. Because the index is always presented, software can stream in an address it wants to admit and read back which table bit to set. Two control inputs change the verdict. A promiscuous control keeps every frame. A broadcast-reject control drops the all-ones address. Frames whose group bit is clear are not hashed and are passed on as unicast candidates for a later station-address compare.

Top module: `mhf_top`

## Requirements
- R1: `byteReady` is high at all times except in the single cycle in which `decValid` is high. A byte is taken on every rising edge where `byteValid` and `byteReady` are both high. Idle cycles between bytes are allowed and produce no `decValid`.
- R2: The CRC register starts at 0xFFFFFFFF for every address. Bytes are consumed first byte first, and each byte least significant bit first, for 48 steps. At each step the register shifts left by one, then is XORed with 0x04C11DB7 when the bit shifted out (old bit 31) differs from the data bit.
- R3: `decIndex[5]` equals CRC bit 0. `decIndex[4:0]` equals {CRC[1], CRC[2], CRC[3], CRC[4], CRC[5]}. The looked-up bin is bit `decIndex` of the 64-bit table {high word, low word}: the high word when `decIndex[5]` is 1, at bit position `decIndex[4:0]`.
- R4: `decValid` is high for exactly one cycle, in the cycle after the edge that takes the sixth byte. `decAccept`, `decCode` and `decIndex` are valid in that cycle.
- R5: A rising edge with `tblWrEn` high loads `tblWrData` into the high table word when `tblWrSel` is 1, and into the low word when it is 0. Reset clears both words.
- R6: When the group bit (bit 0 of the first byte) is set and no override applies, `decCode` is 1 with `decAccept` 1 if the bin is set. If the bin is clear, `decCode` is 0 with `decAccept` 0. A table of all ones accepts every group address.
- R7: When the group bit is clear and no override applies, `decCode` is 2 and `decAccept` is 1, whatever the table holds.
- R8: With `bcastRejectEn` high, the address FF:FF:FF:FF:FF:FF gives `decCode` 3 and `decAccept` 0. With it low, that address is hashed like any other group address.
- R9: With `promiscEn` high, every address gives `decCode` 4 and `decAccept` 1. This overrides broadcast reject, the group bit and the table.
- R10: The verdict uses the table contents, `promiscEn` and `bcastRejectEn` as they stand just before the edge that takes the sixth byte. A table write on that same edge affects only later addresses.
- R11: After reset, `byteReady` is 1 and `decValid`, `decAccept`, `decCode` and `decIndex` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Address byte present |
| byteData | input | 8 | Address byte, first byte first |
| byteReady | output | 1 | Block can take a byte |
| tblWrEn | input | 1 | Table word write strobe |
| tblWrSel | input | 1 | 1 = high word, 0 = low word |
| tblWrData | input | 32 | Table word value |
| promiscEn | input | 1 | Keep every frame |
| bcastRejectEn | input | 1 | Drop the all-ones address |
| decValid | output | 1 | One-cycle done pulse |
| decAccept | output | 1 | Frame kept |
| decCode | output | 3 | 0 miss, 1 hit, 2 not hashed, 3 broadcast rejected, 4 promiscuous |
| decIndex | output | 6 | Computed bin index |

## Verification
Two functions can fall in the same cycle: a table word write, and the lookup made on the edge that takes the final address byte. The bench provokes this collision in two steps. First it clears the table. Then it drives a write that sets exactly the bin of the address being streamed, with the write landing on the same edge as the sixth byte. The verdict is judged a miss, because the old table is used. Repeating the same address with no write then shows a hit, which proves the write did land afterwards.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  typedef enum logic [2:0] {
    DEC_MISS       = 3'd0,
    DEC_HIT        = 3'd1,
    DEC_NOT_HASHED = 3'd2,
    DEC_BCAST_REJ  = 3'd3,
    DEC_PROMISC    = 3'd4
  } decCode_t;

  // Strobes from control to datapath, all qualified by an accepted byte.
  typedef struct packed {
    logic step;    // a byte is taken this edge
    logic first;   // it is the first byte of the address
    logic finish;  // it is the last byte of the address
  } ctlStrobe_t;

  // One byte of serial CRC, least significant data bit first.
  function automatic logic [31:0] crcByteUpdate(
    input logic [31:0] crcIn,
    input logic [7:0]  dataIn,
    input logic [31:0] poly
  );
    logic [31:0] c;
    logic        topBit;
    c = crcIn;
    for (int b = 0; b < 8; b++) begin
      topBit = c[31];
      c = c << 1;
      if (topBit ^ dataIn[b]) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  output logic       byteReady,
  output ctlStrobe_t strobe
);

  localparam int CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cntQ;
  logic             holdQ;
  logic             take;

  assign byteReady = !holdQ;
  assign take      = byteValid && byteReady;

  always_comb begin
    strobe.step   = take;
    strobe.first  = take && (cntQ == '0);
    strobe.finish = take && (cntQ == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      holdQ <= 1'b0;
    end else begin
      holdQ <= strobe.finish;
      if (take) begin
        if (strobe.finish) cntQ <= '0;
        else               cntQ <= cntQ + 1'b1;
      end
    end
  end

  // R1: byte counter never runs past the last address byte
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= LAST_CNT);

  // R4: the hold after an address lasts a single cycle
  assert_hold_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    holdQ |=> !holdQ);

endmodule

// File: rtl/mhf_datapath.sv
module mhf_datapath
  import mhf_pkg::*;
#(
  parameter int          ADDR_BYTES = 6,
  parameter int          WORD_W     = 32,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7,
  parameter logic [31:0] CRC_INIT   = 32'hFFFFFFFF
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctlStrobe_t                        strobe,
  input  logic [7:0]                        byteData,
  input  logic                              tblWrEn,
  input  logic                              tblWrSel,
  input  logic [WORD_W-1:0]                 tblWrData,
  input  logic                              promiscEn,
  input  logic                              bcastRejectEn,
  output logic                              decValid,
  output logic                              decAccept,
  output logic [2:0]                        decCode,
  output logic [$clog2(2*WORD_W)-1:0]       decIndex
);

  localparam int TBL_BITS = 2 * WORD_W;
  localparam int IDX_W    = $clog2(TBL_BITS);
  localparam int POS_W    = $clog2(WORD_W);

  logic [31:0]         crcQ;
  logic [31:0]         crcNext;
  logic                groupQ;
  logic                allOnesQ;
  logic [WORD_W-1:0]   tblWord [2];
  logic [TBL_BITS-1:0] tblBits;
  logic [POS_W-1:0]    posBits;
  logic [IDX_W-1:0]    hashIdx;
  logic                isBcast;
  decCode_t            codeNext;
  decCode_t            decCodeQ;
  logic                decValidQ;
  logic                decAcceptQ;
  logic [IDX_W-1:0]    decIndexQ;

  // Serial CRC over the incoming byte
  assign crcNext = crcByteUpdate(crcQ, byteData, CRC_POLY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ     <= CRC_INIT;
      groupQ   <= 1'b0;
      allOnesQ <= 1'b0;
    end else if (strobe.step) begin
      crcQ <= strobe.finish ? CRC_INIT : crcNext;
      if (strobe.first) begin
        groupQ   <= byteData[0];
        allOnesQ <= (byteData == 8'hFF);
      end else begin
        allOnesQ <= allOnesQ && (byteData == 8'hFF);
      end
    end
  end

  // Bin index: word select from CRC bit 0, bit position from CRC[POS_W:1] reversed
  for (genvar g = 0; g < POS_W; g++) begin : g_rev
    assign posBits[g] = crcNext[POS_W - g];
  end
  assign hashIdx = {crcNext[0], posBits};

  // Two table words, each with its own write decode
  for (genvar w = 0; w < 2; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN)                                 tblWord[w] <= '0;
      else if (tblWrEn && (tblWrSel == w[0]))    tblWord[w] <= tblWrData;
    end
  end
  assign tblBits = {tblWord[1], tblWord[0]};

  assign isBcast = allOnesQ && (byteData == 8'hFF);

  always_comb begin
    if (promiscEn)                    codeNext = DEC_PROMISC;
    else if (bcastRejectEn && isBcast) codeNext = DEC_BCAST_REJ;
    else if (!groupQ)                 codeNext = DEC_NOT_HASHED;
    else if (tblBits[hashIdx])        codeNext = DEC_HIT;
    else                              codeNext = DEC_MISS;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValidQ  <= 1'b0;
      decAcceptQ <= 1'b0;
      decCodeQ   <= DEC_MISS;
      decIndexQ  <= '0;
    end else begin
      decValidQ <= strobe.finish;
      if (strobe.finish) begin
        decCodeQ   <= codeNext;
        decIndexQ  <= hashIdx;
        decAcceptQ <= (codeNext == DEC_HIT) || (codeNext == DEC_NOT_HASHED) ||
                      (codeNext == DEC_PROMISC);
      end
    end
  end

  assign decValid  = decValidQ;
  assign decAccept = decAcceptQ;
  assign decCode   = decCodeQ;
  assign decIndex  = decIndexQ;

  // R9: promiscuous at the deciding edge always keeps the frame
  assert_promisc_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (decValidQ && $past(promiscEn)) |-> (decAcceptQ && decCodeQ == DEC_PROMISC));

  // R7: a not-hashed verdict is always kept
  assert_unicast_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (decValidQ && decCodeQ == DEC_NOT_HASHED) |-> decAcceptQ);

  // R8: broadcast rejection only occurs while its control was set
  assert_bcast_needs_ctl_R8: assert property (@(posedge clk) disable iff (!rstN)
    (decValidQ && decCodeQ == DEC_BCAST_REJ) |-> ($past(bcastRejectEn) && !decAcceptQ));

endmodule

// File: rtl/mhf_top.sv
module mhf_top
  import mhf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  output logic        byteReady,
  input  logic        tblWrEn,
  input  logic        tblWrSel,
  input  logic [31:0] tblWrData,
  input  logic        promiscEn,
  input  logic        bcastRejectEn,
  output logic        decValid,
  output logic        decAccept,
  output logic [2:0]  decCode,
  output logic [5:0]  decIndex
);

  localparam int ADDR_BYTES = 6;
  localparam int WORD_W     = 32;

  ctlStrobe_t strobe;

  mhf_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteReady (byteReady),
    .strobe    (strobe)
  );

  mhf_datapath #(
    .ADDR_BYTES (ADDR_BYTES),
    .WORD_W     (WORD_W),
    .CRC_POLY   (32'h04C11DB7),
    .CRC_INIT   (32'hFFFFFFFF)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .byteData      (byteData),
    .tblWrEn       (tblWrEn),
    .tblWrSel      (tblWrSel),
    .tblWrData     (tblWrData),
    .promiscEn     (promiscEn),
    .bcastRejectEn (bcastRejectEn),
    .decValid      (decValid),
    .decAccept     (decAccept),
    .decCode       (decCode),
    .decIndex      (decIndex)
  );

  // R1: no byte is taken while a verdict is presented
  assert_no_ready_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> !byteReady);

  // R4: the done pulse is one cycle wide
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);

endmodule

// File: tb/test_mhf_top.sv
`timescale 1ns/1ps
module test_mhf_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        byteReady;
  logic        tblWrEn = 1'b0;
  logic        tblWrSel = 1'b0;
  logic [31:0] tblWrData = '0;
  logic        promiscEn = 1'b0;
  logic        bcastRejectEn = 1'b0;
  logic        decValid;
  logic        decAccept;
  logic [2:0]  decCode;
  logic [5:0]  decIndex;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  mhf_top i_mhf_top (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .tblWrEn(tblWrEn), .tblWrSel(tblWrSel),
    .tblWrData(tblWrData), .promiscEn(promiscEn), .bcastRejectEn(bcastRejectEn),
    .decValid(decValid), .decAccept(decAccept), .decCode(decCode), .decIndex(decIndex)
  );

  typedef struct packed {
    logic [47:0] addr;   // first byte in bits 47:40
    logic        prom;
    logic        brej;
    logic [63:0] tbl;    // {high word, low word}
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{48'h01005E000001, 1'b0, 1'b0, 64'h0},
    '{48'h01005E000001, 1'b0, 1'b0, 64'hFFFFFFFF_FFFFFFFF},
    '{48'h3333000000FB, 1'b0, 1'b0, 64'h0},
    '{48'h0A1B2C3D4E5F, 1'b0, 1'b0, 64'h0},
    '{48'hFFFFFFFFFFFF, 1'b0, 1'b1, 64'hFFFFFFFF_FFFFFFFF},
    '{48'hFFFFFFFFFFFF, 1'b0, 1'b0, 64'hFFFFFFFF_FFFFFFFF},
    '{48'hFFFFFFFFFFFF, 1'b1, 1'b1, 64'h0},
    '{48'h0A1B2C3D4E5F, 1'b1, 1'b0, 64'h0},
    '{48'h01005E7FFFFA, 1'b0, 1'b0, 64'hAAAA5555_0F0FF0F0},
    '{48'h0180C2000000, 1'b0, 1'b0, 64'h5555AAAA_F0F00F0F}
  };

  // Reference model written from R2/R3
  function automatic logic [31:0] refCrc(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    logic        top;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      b = a[47 - 8*i -: 8];
      for (int k = 0; k < 8; k++) begin
        top = c[31];
        c = c << 1;
        if (top != b[k]) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  function automatic logic [5:0] refIdx(input logic [47:0] a);
    logic [31:0] c;
    c = refCrc(a);
    return {c[0], c[1], c[2], c[3], c[4], c[5]};
  endfunction

  function automatic logic [2:0] refCode(input logic [47:0] a, input logic p,
                                         input logic r, input logic [63:0] t);
    if (p) return 3'd4;
    if (r && a == 48'hFFFFFFFFFFFF) return 3'd3;
    if (!a[40]) return 3'd2;
    return t[refIdx(a)] ? 3'd1 : 3'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeTable(input logic [63:0] t);
    tblWrEn = 1'b1; tblWrSel = 1'b1; tblWrData = t[63:32];
    @(posedge clk); @(negedge clk);
    tblWrSel = 1'b0; tblWrData = t[31:0];
    @(posedge clk); @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  // Streams one address; returns at the negedge where the verdict is visible.
  task automatic sendAddr(input logic [47:0] a, input int gap, input logic lateWr,
                          input logic lateSel, input logic [31:0] lateData);
    for (int i = 0; i < 6; i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          byteValid = 1'b0;
          @(posedge clk); @(negedge clk);
          check("R1 no done during idle gap", decValid, 0);
        end
      end
      check("R1 ready while streaming", byteReady, 1);
      byteValid = 1'b1;
      byteData  = a[47 - 8*i -: 8];
      if (i == 5 && lateWr) begin
        tblWrEn = 1'b1; tblWrSel = lateSel; tblWrData = lateData;
      end
      @(posedge clk); @(negedge clk);
      byteValid = 1'b0;
      tblWrEn   = 1'b0;
      if (i < 5) check("R4 no done before last byte", decValid, 0);
    end
  endtask

  task automatic judge(input string tag, input logic [47:0] a, input logic [2:0] ec,
                       input logic [5:0] ei);
    check({tag, " R4 done pulse"}, decValid, 1);
    check({tag, " R1 ready low with done"}, byteReady, 0);
    check({tag, " R6 code"}, decCode, ec);
    check({tag, " R6 accept"}, decAccept,
          (ec == 3'd1 || ec == 3'd2 || ec == 3'd4) ? 1 : 0);
    check({tag, " R2 R3 index"}, decIndex, ei);
    @(posedge clk); @(negedge clk);
    check({tag, " R4 done one cycle"}, decValid, 0);
    check({tag, " R1 ready back"}, byteReady, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset values
    check("R11 ready", byteReady, 1);
    check("R11 done", decValid, 0);
    check("R11 accept", decAccept, 0);
    check("R11 code", decCode, 0);
    check("R11 index", decIndex, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table: R6 R7 R8 R9 (and R5 via table loads)
    for (int v = 0; v < NVEC; v++) begin
      writeTable(VECS[v].tbl);
      promiscEn     = VECS[v].prom;
      bcastRejectEn = VECS[v].brej;
      sendAddr(VECS[v].addr, 0, 1'b0, 1'b0, '0);
      judge($sformatf("vec%0d", v), VECS[v].addr,
            refCode(VECS[v].addr, VECS[v].prom, VECS[v].brej, VECS[v].tbl),
            refIdx(VECS[v].addr));
    end
    promiscEn = 1'b0;
    bcastRejectEn = 1'b0;

    // R3 R5: single-bin table hits, its complement misses
    for (int k = 0; k < 3; k++) begin
      logic [47:0] a;
      logic [63:0] t;
      a = (k == 0) ? 48'h01005E000001 : (k == 1) ? 48'h0180C2000000 : 48'h3333000000FB;
      t = 64'h1 << refIdx(a);
      writeTable(t);
      sendAddr(a, 0, 1'b0, 1'b0, '0);
      judge("R3 single bin", a, 3'd1, refIdx(a));
      writeTable(~t);
      sendAddr(a, 0, 1'b0, 1'b0, '0);
      judge("R3 complement", a, 3'd0, refIdx(a));
    end

    // R1: idle gaps between bytes
    writeTable(64'hFFFFFFFF_FFFFFFFF);
    sendAddr(48'h3333000000FB, 2, 1'b0, 1'b0, '0);
    judge("R1 gaps", 48'h3333000000FB, 3'd1, refIdx(48'h3333000000FB));

    // R10: table write on the deciding edge uses the old table
    begin
      logic [47:0] a;
      logic [5:0]  ix;
      a  = 48'h01005E000001;
      ix = refIdx(a);
      writeTable(64'h0);
      sendAddr(a, 0, 1'b1, ix[5], 32'h1 << ix[4:0]);
      judge("R10 old table", a, 3'd0, ix);
      sendAddr(a, 0, 1'b0, 1'b0, '0);
      judge("R10 new table", a, 3'd1, ix);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule